// File: doc/BRIEF.md
# PCI Slot Hotplug Register Controller

This block keeps the insert and remove state of up to 32 PCI slots and lets platform firmware reach that state through a small I/O window at 0xAE00. The window holds four dword registers at offsets 0x0, 0x4, 0x8 and 0xC. The platform reports slot activity with per-slot pulse vectors:

- a hot insert,
- a hot remove,
- a cold insert for devices found at power-on.

The block answers with a one-cycle request to raise bit 1 of the general-purpose event status on every hot event.

Firmware reads three views from the window:

- the slots to re-check (present and removable),
- the slots waiting to be removed,
- the mask of removable slots.

It acknowledges a removal by writing a slot bitmap to the eject register. The block then retires the lowest slot in that bitmap and, if the slot is removable, pulses a per-slot release line so the surrounding logic can free the device. A synchronous reset completes every outstanding removal and rebuilds the present and removable masks from the live slot occupancy and the non-removable mask.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the slot views are rebuilt:
  - offset 0x4 reads 0.
  - offset 0xC reads the inverse of `fixed_slots`, with bits 31:24 forced to 0.
  - offset 0x0 reads `occupied & ~fixed_slots`.
- R2: A reset cycle completes outstanding removals. `slot_release` shows `pending & ~fixed_slots` in the following cycle, and those slots are dropped from the present mask.
- R3: A `hot_ins` bit sets that slot's present bit. It also raises `gpe_set` in the next cycle.
- R4: A `hot_rem` bit sets that slot's pending bit, seen at offset 0x4. It raises `gpe_set` in the next cycle and leaves the present mask unchanged.
- R5: A `cold_ins` bit sets the present bit but raises no `gpe_set`.
- R6: A write of a nonzero value V to offset 0x8 selects the slot of the lowest set bit of V and clears its pending bit.
  - If the slot is removable (its 0xC bit is 1), its present bit is also cleared, and `slot_release` carries exactly that bit in the next cycle.
  - A non-removable slot stays present and gets no release.
- R7: A write of 0 to offset 0x8 changes nothing and releases no slot.
- R8: A read is returned on `io_rdata` in the cycle after `io_rd`, and `io_rdata` is 0 in cycles that follow no read. The values are:
  - offset 0x0 returns present AND removable.
  - offset 0x4 returns the pending mask.
  - offset 0x8 returns 0.
  - offset 0xC returns the removable mask with byte 0xF (bits 31:24) reading 0, because the window spans only 15 bytes.
  - Misaligned addresses and addresses outside the window return 0.
- R9: Writes to offsets 0x0, 0x4 and 0xC, to misaligned addresses and to addresses outside the window have no effect.
- R10: When a slot event and an eject of the same slot fall in one cycle, the eject acts first and the event wins. A hot remove leaves the pending bit set, and a hot or cold insert leaves the present bit set.
- R11: `gpe_set` is high in a cycle exactly when the previous cycle, outside reset, had any `hot_ins` or `hot_rem` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | Read strobe for one dword access |
| io_wr | input | 1 | Write strobe for one dword access |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, one cycle after io_rd |
| hot_ins | input | 32 | Per-slot hot insert pulses |
| hot_rem | input | 32 | Per-slot hot remove pulses |
| cold_ins | input | 32 | Per-slot power-on insert pulses |
| fixed_slots | input | 32 | Per-slot non-removable mask, sampled at reset |
| occupied | input | 32 | Per-slot occupancy, sampled at reset |
| slot_release | output | 32 | Per-slot pulse: free the device |
| gpe_set | output | 1 | Pulse: set bit 1 of the event status |

## Verification
The eject write and a slot event can land on the same slot in the same cycle. The bench provokes this in two cases:

- an eject write together with a hot remove of slot 9,
- an eject write together with a hot insert of slot 10.

A behavioural model in the bench applies the eject first and the event second. Every cycle, the model's release pulses and GPE pulse are compared with the design's outputs. Read-backs of the pending and re-check registers then show that the event survived.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int REG_W = 32;

    // Register slot inside the window; index = byte offset / 4.
    typedef enum logic [1:0] {
        REG_RECHECK = 2'd0,
        REG_PENDING = 2'd1,
        REG_EJECT   = 2'd2,
        REG_RMVABLE = 2'd3
    } win_reg_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     hit;
        win_reg_e reg_id;
    } win_cmd_t;

    // Byte b of register r is decoded only when it lies inside the span.
    function automatic logic byte_in_window(win_reg_e r, int unsigned b, int unsigned span);
        return (int'(r) * 4 + int'(b)) < int'(span);
    endfunction

endpackage

// File: rtl/hp_win_decode.sv
module hp_win_decode
    import hp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hAE00,
    parameter int              WIN_SPAN = 15
) (
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output win_cmd_t          cmd
);
    localparam logic [ADDR_W-1:0] SPAN_L = ADDR_W'(WIN_SPAN);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off        = io_addr - WIN_BASE;
        cmd.rd     = io_rd;
        cmd.wr     = io_wr;
        cmd.hit    = (io_addr >= WIN_BASE) && (off < SPAN_L) && (off[1:0] == 2'b00);
        cmd.reg_id = win_reg_e'(off[3:2]);
    end
endmodule

// File: rtl/hp_eject_pick.sv
module hp_eject_pick #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 go,
    input  logic [NUM_SLOTS-1:0] value,
    output logic [NUM_SLOTS-1:0] eject_oh,
    output logic                 eject_go
);
    logic [NUM_SLOTS-1:0] lowest;

    always_comb begin
        lowest   = value & (~value + NUM_SLOTS'(1));
        eject_go = go && (value != '0);
        eject_oh = eject_go ? lowest : '0;
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] occupied,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    input  logic [NUM_SLOTS-1:0] hot_ins,
    input  logic [NUM_SLOTS-1:0] hot_rem,
    input  logic [NUM_SLOTS-1:0] cold_ins,
    input  logic [NUM_SLOTS-1:0] eject_oh,
    output logic [NUM_SLOTS-1:0] present,
    output logic [NUM_SLOTS-1:0] pending,
    output logic [NUM_SLOTS-1:0] hp_en,
    output logic [NUM_SLOTS-1:0] slot_release,
    output logic                 gpe_set
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic pres_n, pend_n, rel_n, retire;

        always_comb begin
            retire = eject_oh[s] && hp_en[s];
            rel_n  = retire;
            // eject first, then incoming events win
            pres_n = (present[s] && !retire) || hot_ins[s] || cold_ins[s];
            pend_n = (pending[s] && !eject_oh[s]) || hot_rem[s];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_release[s] <= pending[s] && !fixed_slots[s];
                present[s]      <= occupied[s] && !(pending[s] && !fixed_slots[s]);
                pending[s]      <= 1'b0;
                hp_en[s]        <= !fixed_slots[s];
            end else begin
                slot_release[s] <= rel_n;
                present[s]      <= pres_n;
                pending[s]      <= pend_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gpe_set <= 1'b0;
        else     gpe_set <= |(hot_ins | hot_rem);
    end
endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int WIN_SPAN  = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  win_cmd_t             cmd,
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [NUM_SLOTS-1:0] pending,
    input  logic [NUM_SLOTS-1:0] hp_en,
    output logic [REG_W-1:0]     rdata
);
    logic [REG_W-1:0] raw, mask, rd_n;

    always_comb begin
        unique case (cmd.reg_id)
            REG_RECHECK: raw = REG_W'(present & hp_en);
            REG_PENDING: raw = REG_W'(pending);
            REG_EJECT:   raw = '0;
            REG_RMVABLE: raw = REG_W'(hp_en);
            default:     raw = '0;
        endcase
        for (int b = 0; b < REG_W / 8; b++) begin
            mask[b*8 +: 8] = byte_in_window(cmd.reg_id, b, WIN_SPAN) ? 8'hFF : 8'h00;
        end
        rd_n = (cmd.rd && cmd.hit) ? (raw & mask) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_n;
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_pkg::*;
#(
    parameter int                NUM_SLOTS = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'hAE00,
    parameter int                WIN_SPAN  = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [REG_W-1:0]     io_wdata,
    output logic [REG_W-1:0]     io_rdata,
    input  logic [NUM_SLOTS-1:0] hot_ins,
    input  logic [NUM_SLOTS-1:0] hot_rem,
    input  logic [NUM_SLOTS-1:0] cold_ins,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    input  logic [NUM_SLOTS-1:0] occupied,
    output logic [NUM_SLOTS-1:0] slot_release,
    output logic                 gpe_set
);
    win_cmd_t             cmd;
    logic [NUM_SLOTS-1:0] eject_oh, present, pending, hp_en;
    logic                 eject_go, wr_eject;

    hp_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) u_dec (
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .cmd(cmd)
    );

    assign wr_eject = cmd.wr && cmd.hit && (cmd.reg_id == REG_EJECT);

    hp_eject_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .go(wr_eject), .value(io_wdata[NUM_SLOTS-1:0]),
        .eject_oh(eject_oh), .eject_go(eject_go)
    );

    hp_slot_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk(clk), .rst(rst), .occupied(occupied), .fixed_slots(fixed_slots),
        .hot_ins(hot_ins), .hot_rem(hot_rem), .cold_ins(cold_ins),
        .eject_oh(eject_oh), .present(present), .pending(pending),
        .hp_en(hp_en), .slot_release(slot_release), .gpe_set(gpe_set)
    );

    hp_read_mux #(.NUM_SLOTS(NUM_SLOTS), .WIN_SPAN(WIN_SPAN)) u_rmux (
        .clk(clk), .rst(rst), .cmd(cmd), .present(present),
        .pending(pending), .hp_en(hp_en), .rdata(io_rdata)
    );

    logic unused_go;
    assign unused_go = eject_go;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
    parameter int                NUM_SLOTS = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'hAE00
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [ADDR_W-1:0]    io_addr,
    input logic [31:0]          io_wdata,
    input logic [31:0]          io_rdata,
    input logic [NUM_SLOTS-1:0] hot_ins,
    input logic [NUM_SLOTS-1:0] hot_rem,
    input logic [NUM_SLOTS-1:0] cold_ins,
    input logic [NUM_SLOTS-1:0] slot_release,
    input logic                 gpe_set
);
    localparam logic [ADDR_W-1:0] EJ_ADDR  = WIN_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] RMV_ADDR = WIN_BASE + ADDR_W'(12);

    p_gpe_follow_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gpe_set == |$past(hot_ins | hot_rem)));

    p_gpe_cold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        ((cold_ins != '0) && (hot_ins == '0) && (hot_rem == '0)) |=> !gpe_set);

    p_release_single_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $onehot0(slot_release));

    p_release_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> (slot_release == '0));

    p_eject_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_wdata == 32'd0) |=> (slot_release == '0));

    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> (io_rdata == 32'd0));

    p_eject_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == EJ_ADDR) |=> (io_rdata == 32'd0));

    p_rmv_top_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == RMV_ADDR) |=> (io_rdata[31:24] == 8'd0));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
) u_chk (.*);

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb;
    localparam logic [15:0] BASE = 16'hAE00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0, io_rdata;
    logic [31:0] hot_ins = '0, hot_rem = '0, cold_ins = '0;
    logic [31:0] fixed_slots = 32'h0000_0003, occupied = 32'h0000_0F0F;
    logic [31:0] slot_release;
    logic        gpe_set;

    always #5 clk = ~clk;

    hp_slot_ctrl u_dut (
        .clk(clk), .rst(rst), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hot_ins(hot_ins),
        .hot_rem(hot_rem), .cold_ins(cold_ins), .fixed_slots(fixed_slots),
        .occupied(occupied), .slot_release(slot_release), .gpe_set(gpe_set)
    );

    int    total = 0, bad = 0, cycles = 0;
    string tag = "R1";

    // behavioural reference
    bit [31:0] m_pres = '0, m_pend = '0, m_en = '0;
    bit [31:0] e_rel = '0, e_rd = '0;
    bit        e_gpe = 1'b0;

    function automatic bit [31:0] model_read(bit [15:0] a);
        case (a)
            BASE + 16'd0:  return m_pres & m_en;
            BASE + 16'd4:  return m_pend;
            BASE + 16'd8:  return 32'd0;
            BASE + 16'd12: return m_en & 32'h00FF_FFFF;
            default:       return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e_rel  = m_pend & ~fixed_slots;
            m_pres = occupied & ~(m_pend & ~fixed_slots);
            m_pend = '0;
            m_en   = ~fixed_slots;
            e_gpe  = 1'b0;
            e_rd   = '0;
        end else begin
            e_rd  = io_rd ? model_read(io_addr) : 32'd0;
            e_rel = '0;
            if (io_wr && io_addr == BASE + 16'd8 && io_wdata != 0) begin
                for (int i = 0; i < 32; i++) begin
                    if (io_wdata[i]) begin
                        m_pend[i] = 1'b0;
                        if (m_en[i]) begin
                            m_pres[i] = 1'b0;
                            e_rel[i]  = 1'b1;
                        end
                        break;
                    end
                end
            end
            e_gpe = 1'b0;
            for (int i = 0; i < 32; i++) begin
                if (hot_ins[i] || cold_ins[i]) m_pres[i] = 1'b1;
                if (hot_rem[i]) m_pend[i] = 1'b1;
                if (hot_ins[i] || hot_rem[i]) e_gpe = 1'b1;
            end
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("slot_release", slot_release, e_rel);
            check("gpe_set", {31'd0, gpe_set}, {31'd0, e_gpe});
            check("io_rdata", io_rdata, e_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            bad++;
            $display("FAIL watchdog (all) actual=%0d expected<=5000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        io_rd = 0; io_wr = 0; hot_ins = '0; hot_rem = '0; cold_ins = '0;
    endtask

    task automatic rd(logic [15:0] a);
        io_rd = 1; io_addr = a; step();
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        io_wr = 1; io_addr = a; io_wdata = d; step();
    endtask

    task automatic read_all();
        rd(BASE); rd(BASE + 16'd4); rd(BASE + 16'd8); rd(BASE + 16'd12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1"; read_all(); step();

        tag = "R3"; hot_ins = 32'h0010_0000; step(); rd(BASE); step();
        tag = "R5"; cold_ins = 32'h0000_1000; step(); rd(BASE); step();
        tag = "R4"; hot_rem = 32'h0010_0020; step(); rd(BASE + 16'd4); rd(BASE); step();

        tag = "R6"; wr(BASE + 16'd8, 32'h0010_0020); step();
        rd(BASE + 16'd4); rd(BASE);
        hot_rem = 32'h0000_0002; step();
        wr(BASE + 16'd8, 32'h0000_0002); step(); rd(BASE + 16'd4); step();

        tag = "R7"; wr(BASE + 16'd8, 32'h0); step(); read_all();

        tag = "R9";
        wr(BASE, 32'hFFFF_FFFF); wr(BASE + 16'd4, 32'hFFFF_FFFF);
        wr(BASE + 16'd12, 32'h0); wr(BASE + 16'd9, 32'h0000_0100);
        wr(BASE + 16'd16, 32'h0000_0100); wr(16'hAE08 - 16'h100, 32'h0000_0100);
        read_all();

        tag = "R8";
        rd(BASE + 16'd12); rd(BASE + 16'd2); rd(BASE + 16'd15);
        rd(BASE + 16'd16); rd(BASE - 16'd4); step();

        tag = "R10";
        io_wr = 1; io_addr = BASE + 16'd8; io_wdata = 32'h0000_0200; hot_rem = 32'h0000_0200; step();
        rd(BASE + 16'd4); rd(BASE);
        io_wr = 1; io_addr = BASE + 16'd8; io_wdata = 32'h0000_0400; hot_ins = 32'h0000_0400; step();
        rd(BASE); rd(BASE + 16'd4); step();

        tag = "R11";
        hot_ins = 32'h8000_0000; step();
        hot_rem = 32'h4000_0000; step();
        cold_ins = 32'h2000_0000; step();
        hot_rem = 32'h8000_0000; step(); step();

        tag = "R2";
        hot_rem = 32'h0000_0004; step();
        rst = 1; @(negedge clk); rst = 0;
        read_all(); step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule